// File: doc/BRIEF.md
# Termination Impedance Calibration Controller

This block runs the digital search that trims a termination resistor leg against an external precision reference. A voltage comparator at the reference pad reports whether the pad sits above or below half the supply. After a start request the controller first reads that comparator to pick a search direction. It then moves a 5-bit trial code one step at a time until the comparator flips, which marks the point where the leg matches the reference. The code found is then frozen and published, so that the other termination legs (half, quarter and sixth of the reference value) and the driver pull-down can reuse it across all data pins.

Next to the shared reference code the controller keeps a second, local code that follows every search step. A single coupling-enable line, driven by a per-pin variation comparison, doubles the size of each local step. A pin that drifts more than the reference can then be corrected with twice as many calibration cells toggling, and only one wire is needed to reach it instead of a full code bus. The comparator output is asynchronous to the controller. It passes through a two-stage synchronizer, and every new trial code is given a fixed settle window before it is judged. Both codes saturate at 0 and 31. A search that hits a limit without a flip raises an error and leaves the published codes unchanged.

Top module: `term_cal_ctrl`

## Requirements
- R1: After reset, trial, published reference and published local codes all equal 16, and busy_o, done_o and err_o are low.
- R2: A start_i pulse seen while idle makes busy_o high and loads the trial code with 16 on the following cycle.
- R3: The comparator level (1 = pad above half supply, code too low) sampled after the first settle window sets the direction: 1 steps the code upward, 0 steps it downward.
- R4: On an upward search the trial code locks at the first code for which the comparator reads 0.
- R5: On a downward search the trial code locks at the first code for which the comparator reads 1.
- R6: On lock, done_o is high for exactly one cycle and busy_o falls. The published codes change only in that cycle.
- R7: The trial code never wraps. If the search direction points past 31 or below 0 with no flip, err_o is set, done_o stays low and the published codes keep their previous values.
- R8: The local code starts at 16 and moves with every trial step in the same direction: by 1 when couple_en_i is low and by 2 when it is high, clamped to 0..31.
- R9: A start_i pulse during a search is ignored: the result and its timing are unchanged.
- R10: err_o holds until the next accepted start, which clears it.
- R11: Each trial code is held for 3 cycles before it is judged. done_o or err_o therefore rises 3*(n+1) clock edges after the edge that accepts start, where n is the number of steps taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a calibration when idle |
| cmp_i | input | 1 | Asynchronous comparator: 1 = pad above half supply |
| couple_en_i | input | 1 | Coupling enable: doubles the local step |
| trial_code_o | output | 5 | Code driven to the reference leg during the search |
| ref_code_o | output | 5 | Published reference code for all pins |
| loc_code_o | output | 5 | Published local (coupled) code |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle lock pulse |
| err_o | output | 1 | Search saturated without a flip |

## Verification
The comparator is modelled as a threshold on the trial code. Thresholds above and below the start point separate the upward search from the downward one and the lock rule each one uses. Thresholds beyond either end of the range force saturation, which shows that the code clamps and that err_o does not coexist with done_o. Running the same searches with the coupling line high and low separates the single local step from the double one, including the local clamp. A repeated start in the middle of a search, and counting edges to the lock, expose any change to the settle window or to the restart behaviour.

// File: rtl/tcal_pkg.sv
package tcal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_SEARCH = 2'd2
    } tcal_state_e;
endpackage

// File: rtl/tcal_sync.sv
module tcal_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/tcal_step.sv
module tcal_step #(
    parameter int W = 5
) (
    input  logic [W-1:0] cur_i,
    input  logic         up_i,
    input  logic         dbl_i,
    output logic [W-1:0] nxt_o
);
    localparam int MAXV = (1 << W) - 1;

    logic [W:0] amt;
    logic [W:0] sum;

    always_comb begin
        amt = dbl_i ? (W+1)'(2) : (W+1)'(1);
        sum = {1'b0, cur_i} + amt;
        if (up_i) begin
            nxt_o = (sum > (W+1)'(MAXV)) ? W'(MAXV) : sum[W-1:0];
        end else begin
            nxt_o = ({1'b0, cur_i} < amt) ? '0 : W'({1'b0, cur_i} - amt);
        end
    end
endmodule

// File: rtl/term_cal_ctrl.sv
module term_cal_ctrl #(
    parameter int CODE_W     = 5,
    parameter int START_CODE = 16,
    parameter int SETTLE     = 3,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              cmp_i,
    input  logic              couple_en_i,
    output logic [CODE_W-1:0] trial_code_o,
    output logic [CODE_W-1:0] ref_code_o,
    output logic [CODE_W-1:0] loc_code_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    import tcal_pkg::*;

    localparam int                 MAXV   = (1 << CODE_W) - 1;
    localparam int                 SW     = $clog2(SETTLE + 1);
    localparam logic [SW-1:0]      WAIT0  = SW'(SETTLE - 1);
    localparam logic [CODE_W-1:0]  CSTART = CODE_W'(START_CODE);

    typedef struct packed {
        tcal_state_e       state;
        logic [CODE_W-1:0] trial;
        logic [CODE_W-1:0] loc;
        logic [CODE_W-1:0] ref_pub;
        logic [CODE_W-1:0] loc_pub;
        logic [SW-1:0]     wait_cnt;
        logic              dir_up;
        logic              done;
        logic              err;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic              cmp_s;
    logic              up_sel;
    logic              at_lim;
    logic [CODE_W-1:0] trial_nxt;
    logic [CODE_W-1:0] loc_nxt;

    tcal_sync #(.STAGES(SYNC_STG)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_i),
        .sync_o  (cmp_s)
    );

    // direction: freshly sampled in the first window, remembered afterwards
    assign up_sel = (r_q.state == ST_SAMPLE) ? cmp_s : r_q.dir_up;
    assign at_lim = up_sel ? (r_q.trial == CODE_W'(MAXV)) : (r_q.trial == '0);

    tcal_step #(.W(CODE_W)) ref_step_i (
        .cur_i (r_q.trial),
        .up_i  (up_sel),
        .dbl_i (1'b0),
        .nxt_o (trial_nxt)
    );

    tcal_step #(.W(CODE_W)) loc_step_i (
        .cur_i (r_q.loc),
        .up_i  (up_sel),
        .dbl_i (couple_en_i),
        .nxt_o (loc_nxt)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.wait_cnt != '0) r_d.wait_cnt = r_q.wait_cnt - SW'(1);

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state    = ST_SAMPLE;
                    r_d.trial    = CSTART;
                    r_d.loc      = CSTART;
                    r_d.wait_cnt = WAIT0;
                    r_d.err      = 1'b0;
                end
            end
            ST_SAMPLE, ST_SEARCH: begin
                if (r_q.wait_cnt == '0) begin
                    if (r_q.state == ST_SEARCH && cmp_s != r_q.dir_up) begin
                        r_d.state   = ST_IDLE;
                        r_d.done    = 1'b1;
                        r_d.ref_pub = r_q.trial;
                        r_d.loc_pub = r_q.loc;
                    end else if (at_lim) begin
                        r_d.state = ST_IDLE;
                        r_d.err   = 1'b1;
                    end else begin
                        r_d.state    = ST_SEARCH;
                        r_d.dir_up   = up_sel;
                        r_d.trial    = trial_nxt;
                        r_d.loc      = loc_nxt;
                        r_d.wait_cnt = WAIT0;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.trial    <= CSTART;
            r_q.loc      <= CSTART;
            r_q.ref_pub  <= CSTART;
            r_q.loc_pub  <= CSTART;
            r_q.wait_cnt <= '0;
            r_q.dir_up   <= 1'b0;
            r_q.done     <= 1'b0;
            r_q.err      <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign trial_code_o = r_q.trial;
    assign ref_code_o   = r_q.ref_pub;
    assign loc_code_o   = r_q.loc_pub;
    assign busy_o       = (r_q.state != ST_IDLE);
    assign done_o       = r_q.done;
    assign err_o        = r_q.err;
endmodule

// File: rtl/tcal_chk.sv
module tcal_chk #(
    parameter int CODE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [CODE_W-1:0] trial_code_o,
    input logic [CODE_W-1:0] ref_code_o,
    input logic [CODE_W-1:0] loc_code_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              err_o
);
    localparam logic [CODE_W-1:0] TOP = '1;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    pub_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(ref_code_o) && $stable(loc_code_o)));

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R7
    err_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !done_o);

    // R7
    err_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !busy_o) |-> (trial_code_o == '0 || trial_code_o == TOP));

    // R11
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start_i) |-> (trial_code_o == $past(trial_code_o)
                          || trial_code_o == $past(trial_code_o) + CODE_W'(1)
                          || trial_code_o == $past(trial_code_o) - CODE_W'(1)));
endmodule

bind term_cal_ctrl tcal_chk #(.CODE_W(CODE_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .trial_code_o (trial_code_o),
    .ref_code_o   (ref_code_o),
    .loc_code_o   (loc_code_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .err_o        (err_o)
);

// File: tb/term_cal_ctrl_tb_top.sv
`timescale 1ns/1ps
module term_cal_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       cmp_i;
    logic       couple_en_i = 1'b0;
    logic [4:0] trial_code_o, ref_code_o, loc_code_o;
    logic       busy_o, done_o, err_o;

    int checks = 0;
    int errors = 0;
    int tgt = 16;
    bit finished = 0;

    always #4 clk = ~clk;

    // behavioural comparator: pad above half supply while code is below threshold
    always_comb cmp_i = (int'(trial_code_o) < tgt);

    term_cal_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .couple_en_i(couple_en_i), .trial_code_o(trial_code_o),
        .ref_code_o(ref_code_o), .loc_code_o(loc_code_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One calibration run; expected results derived from the requirements.
    task automatic run_cal(input int t, input bit cpl, input bit restart_mid);
        int c = 16, l = 16, n = 0, d, lat, cnt = 0, dones = 0;
        bit up, e_err = 0;
        int old_ref = int'(ref_code_o), old_loc = int'(loc_code_o);
        up = (16 < t);
        d  = cpl ? 2 : 1;
        forever begin
            if (up) begin
                if (c == 31) begin e_err = 1; break; end
                c++; l = (l + d > 31) ? 31 : l + d; n++;
                if (!(c < t)) break;
            end else begin
                if (c == 0) begin e_err = 1; break; end
                c--; l = (l - d < 0) ? 0 : l - d; n++;
                if (c < t) break;
            end
        end
        lat = 3 * (n + 1) + 1;

        @(negedge clk);
        tgt = t; couple_en_i = cpl; start_i = 1'b1;
        forever begin
            @(negedge clk);
            cnt++;
            start_i = (restart_mid && cnt == 5);
            if (cnt == 1) begin
                check(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
                check(int'(trial_code_o) == 16, "R2 trial load", int'(trial_code_o), 16);
                check(err_o == 1'b0, "R10 err cleared by start", int'(err_o), 0);
            end
            if (done_o) dones++;
            if (done_o || err_o || cnt > 300) break;
        end
        start_i = 1'b0;
        check(cnt == lat, restart_mid ? "R9 latency with restart" : "R11 latency", cnt, lat);
        check(int'(err_o) == int'(e_err), "R7 err flag", int'(err_o), int'(e_err));
        if (e_err) begin
            check(dones == 0, "R7 no done on saturation", dones, 0);
            check(int'(trial_code_o) == c, "R7 clamped trial", int'(trial_code_o), c);
            check(int'(ref_code_o) == old_ref, "R7 ref kept", int'(ref_code_o), old_ref);
            check(int'(loc_code_o) == old_loc, "R7 loc kept", int'(loc_code_o), old_loc);
        end else begin
            check(int'(ref_code_o) == c, up ? "R4 up lock" : "R5 down lock", int'(ref_code_o), c);
            check(int'(loc_code_o) == l, "R8 local code", int'(loc_code_o), l);
            check(busy_o == 1'b0, "R6 busy drops", int'(busy_o), 0);
            @(negedge clk);
            check(done_o == 1'b0, "R6 done one cycle", int'(done_o), 0);
        end
        check(busy_o == 1'b0, "R3 search ended", int'(busy_o), 0);
        repeat (3) @(negedge clk);
        check(int'(err_o) == int'(e_err), "R10 err holds", int'(err_o), int'(e_err));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(int'(trial_code_o) == 16, "R1 trial", int'(trial_code_o), 16);
        check(int'(ref_code_o) == 16, "R1 ref", int'(ref_code_o), 16);
        check(int'(loc_code_o) == 16, "R1 loc", int'(loc_code_o), 16);
        check({busy_o, done_o, err_o} == 3'b000, "R1 flags",
              int'({busy_o, done_o, err_o}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_cal(20, 1'b0, 1'b0);   // R3 R4 upward, single local step
        run_cal(10, 1'b1, 1'b0);   // R5 downward, R8 double step
        run_cal(25, 1'b1, 1'b0);   // R8 local clamp at 31
        run_cal(0, 1'b0, 1'b0);    // R7 lower saturation
        run_cal(18, 1'b0, 1'b0);   // R10 start clears error
        run_cal(32, 1'b1, 1'b0);   // R7 upper saturation
        run_cal(3, 1'b1, 1'b1);    // R9 restart ignored, R8 clamp at 0
        run_cal(16, 1'b0, 1'b0);   // R5 threshold at start code
        summary();
    end

    initial begin
        #(200000 * 8);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule